// File: doc/BRIEF.md
# I2C Slave Byte Engine with Clock Stretching

This block is the target side of an I2C link. A host controller reaches it through a small register port. It watches the open-drain SCL and SDA lines through a synchroniser and recognises START and STOP. After a START it collects the first byte, which holds a 7-bit address and a direction bit. If the address equals the block's own address, the block acknowledges the byte and raises an interrupt. From then on it moves whole bytes in the direction that the master requested.

After every completed byte the block holds SCL low. The host then has time to service it. The host chooses transmit or receive in the control register, to match the captured direction bit. In transmit mode it writes the next byte to release the clock. In receive mode it reads the byte just taken, or does a dummy read, to release the clock. When the master answers a sent byte with NACK, the host switches to receive mode and does a dummy read. This frees the clock so that the master can end the transfer with a STOP.

Top module: `i2cs_byte_engine`

## Requirements
- R1: The addressed flag (status bit 1) is set in the same cycle as the byte-done flag at the end of an address byte whose upper seven bits equal the own address. A later data byte that ends the same transfer clears it when its byte-done flag is set.
- R2: Any host write to the control register (select 0) clears the addressed flag. Reads and writes to the other registers leave it unchanged.
- R3: The direction bit (the lowest bit of the address byte) is captured on a match and shown as status bit 2. A value of 1 means the master reads and the block transmits.
- R4: The byte-done flag (status bit 0) is set at the falling edge of the ninth SCL clock of each byte the block takes part in. The `irq` output equals this flag. Writing 1 to status bit 0 clears it.
- R5: Whenever the byte-done flag is set, SCL is held low. With control bit 0 = 1 (transmit), only a write to the data register (select 2) releases SCL. With control bit 0 = 0 (receive), only a read of the data register releases SCL. Any other access leaves SCL held.
- R6: After each transmitted byte, the level of SDA at the ninth rising SCL edge is stored in status bit 3 (1 = NACK).
- R7: The block pulls SDA low during the ninth clock to acknowledge a matching address and each received data byte. It never drives SDA high. A non-matching address gets no acknowledge and sets no flag.
- R8: In transmit mode the byte written to the data register goes out MSB first. Each bit becomes valid while SCL is low.
- R9: A received data byte, assembled MSB first, is readable from the data register once its byte-done flag is set.
- R10: A START at any point begins a new address phase. A STOP returns the engine to idle. Both release SCL and SDA and clear the addressed flag.
- R11: After reset, the control, status and data registers read 0, `irq` is 0 and neither line is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pulls SCL low when 1 |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| irq | output | 1 | Byte-done interrupt |

## Verification
The bus lines reach the state machine through two synchroniser flops and one edge-compare stage. START, STOP and SCL edges therefore act two to three clocks after the line changes. The byte-done flag, the addressed flag and the SCL hold all appear one clock after the detected ninth falling edge. The bench waits six clocks after the master lowers SCL before it reads the status or `irq`. A receive-mode read frees SCL one clock after the strobe. A transmit-mode write frees it two clocks after the strobe, because a setup cycle puts the first bit on SDA before SCL is let go. The bench samples `scl_oe` a few clocks after the access, always at the falling clock edge.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  // status bit positions
  localparam int SB_DONE = 0;
  localparam int SB_AAS  = 1;
  localparam int SB_RW   = 2;
  localparam int SB_NACK = 3;
  localparam int SB_HOLD = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_HOLD,
    ST_SETUP,
    ST_SKIP
  } eng_state_e;

  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [ADDR_W-1:0] own);
    return b[BYTE_W-1:1] == own;
  endfunction

  function automatic logic rw_of(input logic [BYTE_W-1:0] b);
    return b[0];
  endfunction
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2cs_cond_det.sv
module i2cs_cond_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign start_evt = scl_s && scl_p && sda_p && !sda_s;
  assign stop_evt  = scl_s && scl_p && !sda_p && sda_s;
  assign scl_rise  = scl_s && !scl_p;
  assign scl_fall  = !scl_s && scl_p;
endmodule

// File: rtl/i2cs_xfer_fsm.sv
module i2cs_xfer_fsm
  import i2cs_pkg::*;
#(
  parameter logic [ADDR_W-1:0] OWN_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              tx_mode,
  input  logic              rel_rd,
  input  logic              rel_wr,
  input  logic [BYTE_W-1:0] load_byte,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              hold_o,
  output logic              done_set,
  output logic              aas_set,
  output logic              nack_set,
  output logic              nack_val,
  output logic              rx_set,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rw_cap
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  eng_state_e        state;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  bitcnt;
  logic              sda_q, rw_q, nack_q;
  logic              bus_cond, ack_end, byte_end, rel_go;

  assign bus_cond = start_evt || stop_evt;
  assign ack_end  = !bus_cond && scl_fall &&
                    (state == ST_ADDR_ACK || state == ST_RX_ACK || state == ST_TX_ACK);
  assign byte_end = !bus_cond && scl_fall && (bitcnt == LAST) &&
                    (state == ST_ADDR || state == ST_RX);
  assign rel_go   = !bus_cond && (state == ST_HOLD) && (tx_mode ? rel_wr : rel_rd);

  assign done_set = ack_end;
  assign aas_set  = ack_end && (state == ST_ADDR_ACK);
  assign nack_set = ack_end && (state == ST_TX_ACK);
  assign rx_set   = byte_end && (state == ST_RX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      shreg  <= '0;
      bitcnt <= '0;
      sda_q  <= 1'b0;
      rw_q   <= 1'b0;
      nack_q <= 1'b0;
    end else if (bus_cond) begin
      state  <= start_evt ? ST_ADDR : ST_IDLE;
      bitcnt <= '0;
      sda_q  <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_RX: begin
          if (scl_rise) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_end) begin
            if (state == ST_RX) begin
              sda_q <= 1'b1;
              state <= ST_RX_ACK;
            end else if (addr_hit(shreg, OWN_ADDR)) begin
              sda_q <= 1'b1;
              rw_q  <= rw_of(shreg);
              state <= ST_ADDR_ACK;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK, ST_RX_ACK: begin
          if (scl_fall) begin
            sda_q  <= 1'b0;
            bitcnt <= '0;
            state  <= ST_HOLD;
          end
        end
        ST_TX_ACK: begin
          if (scl_rise)      nack_q <= sda_s;
          else if (scl_fall) state  <= ST_HOLD;
        end
        ST_HOLD: begin
          if (rel_go) begin
            if (tx_mode) begin
              shreg  <= load_byte;
              sda_q  <= ~load_byte[BYTE_W-1];
              bitcnt <= CNT_W'(1);
              state  <= ST_SETUP;
            end else begin
              bitcnt <= '0;
              state  <= ST_RX;
            end
          end
        end
        ST_SETUP: state <= ST_TX;
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == LAST) begin
              sda_q <= 1'b0;
              state <= ST_TX_ACK;
            end else begin
              sda_q  <= ~shreg[BYTE_W-2];
              shreg  <= {shreg[BYTE_W-2:0], 1'b0};
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign scl_oe   = (state == ST_HOLD) || (state == ST_SETUP);
  assign hold_o   = (state == ST_HOLD);
  assign sda_oe   = sda_q;
  assign rx_byte  = shreg;
  assign rw_cap   = rw_q;
  assign nack_val = nack_q;
endmodule

// File: rtl/i2cs_byte_engine.sv
module i2cs_byte_engine
  import i2cs_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR    = 7'h2A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic [1:0] reg_sel,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  logic [1:0]        bus_s;
  logic              start_evt, stop_evt, scl_rise, scl_fall;
  logic              eng_hold, done_set, aas_set, nack_set, nack_val, rx_set, rw_cap;
  logic [BYTE_W-1:0] rx_byte;
  logic              ctrl_tx, st_done, st_aas, st_nack;
  logic [BYTE_W-1:0] data_reg;
  logic              wr_ctrl, wr_stat, wr_data, rd_data;

  assign wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);
  assign wr_stat = reg_wr && (reg_sel == SEL_STAT);
  assign wr_data = reg_wr && (reg_sel == SEL_DATA);
  assign rd_data = reg_rd && (reg_sel == SEL_DATA);

  i2cs_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_s)
  );

  i2cs_cond_det cond_i (
    .clk(clk), .rst_n(rst_n), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  i2cs_xfer_fsm #(.OWN_ADDR(OWN_ADDR)) fsm_i (
    .clk(clk), .rst_n(rst_n),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(bus_s[0]),
    .tx_mode(ctrl_tx), .rel_rd(rd_data), .rel_wr(wr_data), .load_byte(reg_wdata),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .hold_o(eng_hold),
    .done_set(done_set), .aas_set(aas_set), .nack_set(nack_set), .nack_val(nack_val),
    .rx_set(rx_set), .rx_byte(rx_byte), .rw_cap(rw_cap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_tx  <= 1'b0;
      st_done  <= 1'b0;
      st_aas   <= 1'b0;
      st_nack  <= 1'b0;
      data_reg <= '0;
    end else begin
      if (wr_ctrl) ctrl_tx <= reg_wdata[0];

      if (done_set)                        st_done <= 1'b1;
      else if (wr_stat && reg_wdata[SB_DONE]) st_done <= 1'b0;

      if (wr_ctrl || start_evt || stop_evt) st_aas <= 1'b0;
      else if (aas_set)                     st_aas <= 1'b1;
      else if (done_set)                    st_aas <= 1'b0;

      if (nack_set) st_nack <= nack_val;

      if (rx_set)       data_reg <= rx_byte;
      else if (wr_data) data_reg <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_CTRL: reg_rdata[0] = ctrl_tx;
      SEL_STAT: begin
        reg_rdata[SB_DONE] = st_done;
        reg_rdata[SB_AAS]  = st_aas;
        reg_rdata[SB_RW]   = rw_cap;
        reg_rdata[SB_NACK] = st_nack;
        reg_rdata[SB_HOLD] = scl_oe;
      end
      SEL_DATA: reg_rdata = data_reg;
      default: ;
    endcase
  end

  assign irq = st_done;
endmodule

// File: rtl/i2cs_byte_engine_chk.sv
module i2cs_byte_engine_chk
  import i2cs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       fsm_hold,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [1:0] reg_sel,
  input logic [7:0] reg_wdata,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       done_set,
  input logic       aas_set,
  input logic       st_done,
  input logic       st_aas
);
  p_aas_with_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_aas) |-> st_done);

  p_data_byte_clears_aas_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done_set && !aas_set) |=> !st_aas);

  p_ctrl_write_clears_aas_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_CTRL) |=> !st_aas);

  p_done_holds_scl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_done) |-> scl_oe);

  p_done_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_STAT && reg_wdata[SB_DONE] && !done_set) |=> !st_done);

  p_hold_without_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_hold && !reg_wr && !reg_rd && !start_evt && !stop_evt) |=> scl_oe);

  p_bus_cond_releases_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || stop_evt) |=> (!scl_oe && !sda_oe && !st_aas));
endmodule

bind i2cs_byte_engine i2cs_byte_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
  .fsm_hold(eng_hold), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .done_set(done_set), .aas_set(aas_set), .st_done(st_done), .st_aas(st_aas)
);

// File: tb/i2cs_byte_engine_tb.sv
module i2cs_byte_engine_tb_top;
  localparam int         CLK_PERIOD = 10;
  localparam int         H          = 10;
  localparam int         WDOG       = 100000;
  localparam logic [6:0] OWN        = 7'h2A;
  localparam int         NVEC       = 6;
  // {addr[6:0], rw, first byte, second byte}
  localparam logic [23:0] VECS [NVEC] = '{
    {7'h2A, 1'b0, 8'hA5, 8'h00},
    {7'h2A, 1'b1, 8'h96, 8'h5A},
    {7'h15, 1'b0, 8'hFF, 8'h00},
    {7'h2A, 1'b0, 8'h01, 8'h00},
    {7'h2B, 1'b1, 8'h00, 8'h00},
    {7'h2A, 1'b1, 8'h80, 8'h7F}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       scl_oe, sda_oe, irq;
  logic [1:0] reg_sel = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  wire        scl_line = scl_m & ~scl_oe;
  wire        sda_line = sda_m & ~sda_oe;
  int         n_checks = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cs_byte_engine #(.OWN_ADDR(OWN), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_line) @(negedge clk);
  endtask

  task automatic host_wr(input logic [1:0] sel, input logic [7:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] sel, output logic [7:0] d);
    reg_sel = sel; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_cyc(2);
    scl_m = 1'b1; wait_scl_high(); wait_cyc(H);
    sda_m = 1'b0; wait_cyc(H);
    scl_m = 1'b0; wait_cyc(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_cyc(H);
    scl_m = 1'b1; wait_scl_high(); wait_cyc(H);
    sda_m = 1'b1; wait_cyc(H);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wait_cyc(H);
    scl_m = 1'b1; wait_scl_high(); wait_cyc(H);
    scl_m = 1'b0; wait_cyc(2);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; wait_cyc(H);
    scl_m = 1'b1; wait_scl_high(); wait_cyc(H/2);
    b = sda_line; wait_cyc(H/2);
    scl_m = 1'b0; wait_cyc(2);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    for (int k = 7; k >= 0; k--) send_bit(v[k]);
    recv_bit(ack);
  endtask

  task automatic recv_byte(input logic ack_bit, output logic [7:0] v);
    logic b;
    for (int k = 7; k >= 0; k--) begin
      recv_bit(b);
      v[k] = b;
    end
    send_bit(ack_bit);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    logic [7:0] rd, got;
    logic       ack;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(3);

    // R11 reset state
    check("R11 scl_oe", scl_oe, 0);
    check("R11 sda_oe", sda_oe, 0);
    check("R11 irq", irq, 0);
    host_rd(2'd0, rd); check("R11 ctrl", rd, 0);
    host_rd(2'd1, rd); check("R11 status", rd, 0);
    host_rd(2'd2, rd); check("R11 data", rd, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [6:0] a;
      logic       rw, hit;
      logic [7:0] d0, d1;
      a  = VECS[i][23:17];
      rw = VECS[i][16];
      d0 = VECS[i][15:8];
      d1 = VECS[i][7:0];
      hit = (a == OWN);
      bus_start();
      send_byte({a, rw}, ack);
      wait_cyc(6);
      if (!hit) begin
        check("R7 miss no ack", ack, 1);
        check("R7 miss no irq", irq, 0);
        send_byte(d0, ack);
        wait_cyc(6);
        check("R7 miss data no ack", ack, 1);
        check("R7 miss no stretch", scl_oe, 0);
      end else begin
        check("R7 address ack", ack, 0);
        check("R4 irq after address", irq, 1);
        check("R5 stretch after address", scl_oe, 1);
        host_rd(2'd1, rd);
        check("R1 addressed set", rd[1], 1);
        check("R3 direction bit", rd[2], rw);
        host_wr(2'd0, {7'd0, rw});
        host_rd(2'd1, rd);
        check("R2 ctrl write clears addressed", rd[1], 0);
        host_wr(2'd1, 8'h01);
        check("R4 done cleared by write 1", irq, 0);
        if (!rw) begin
          host_rd(2'd2, rd);
          wait_cyc(3);
          check("R5 read releases in rx", scl_oe, 0);
          send_byte(d0, ack);
          wait_cyc(6);
          check("R7 data ack", ack, 0);
          check("R4 irq after data", irq, 1);
          host_rd(2'd2, rd);
          check("R9 received byte", rd, d0);
          host_wr(2'd1, 8'h01);
        end else begin
          host_wr(2'd2, d0);
          wait_cyc(4);
          check("R5 write releases in tx", scl_oe, 0);
          recv_byte(1'b0, got);
          wait_cyc(6);
          check("R8 first sent byte", got, d0);
          host_rd(2'd1, rd);
          check("R6 ack captured", rd[3], 0);
          check("R4 irq after tx byte", rd[0], 1);
          host_wr(2'd1, 8'h01);
          host_wr(2'd2, d1);
          wait_cyc(4);
          recv_byte(1'b1, got);
          wait_cyc(6);
          check("R8 second sent byte", got, d1);
          host_rd(2'd1, rd);
          check("R6 nack captured", rd[3], 1);
          check("R5 stretch after nack", scl_oe, 1);
          host_wr(2'd0, 8'h00);
          host_wr(2'd1, 8'h01);
          host_rd(2'd2, rd);
          wait_cyc(3);
          check("R5 dummy read releases after nack", scl_oe, 0);
        end
        bus_stop();
        wait_cyc(4);
        check("R10 lines free after stop", {scl_oe, sda_oe}, 0);
      end
      if (!hit) bus_stop();
    end

    // Directed: wrong access kept stretched, data byte clears addressed,
    // unexpected START, STOP clears addressed.
    bus_start();
    send_byte({OWN, 1'b0}, ack);
    wait_cyc(6);
    check("R7 directed address ack", ack, 0);
    host_wr(2'd1, 8'h01);
    host_wr(2'd2, 8'h33);
    host_rd(2'd0, rd);
    wait_cyc(40);
    check("R5 write ignored in rx mode", scl_oe, 1);
    host_rd(2'd1, rd);
    check("R2 other accesses keep addressed", rd[1], 1);
    host_rd(2'd2, rd);
    wait_cyc(3);
    check("R5 read releases", scl_oe, 0);
    send_byte(8'hC3, ack);
    wait_cyc(6);
    check("R7 directed data ack", ack, 0);
    host_rd(2'd1, rd);
    check("R1 data byte done", rd[0], 1);
    check("R1 addressed clear on data byte", rd[1], 0);
    host_rd(2'd2, rd);
    check("R9 directed byte", rd, 8'hC3);
    host_wr(2'd1, 8'h01);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    check("R10 start releases scl", scl_oe, 0);
    check("R10 start releases sda", sda_oe, 0);
    send_byte({OWN, 1'b0}, ack);
    wait_cyc(6);
    check("R10 new address phase after start", ack, 0);
    host_wr(2'd1, 8'h01);
    host_rd(2'd2, rd);
    wait_cyc(3);
    host_rd(2'd1, rd);
    check("R1 addressed after restart", rd[1], 1);
    bus_stop();
    wait_cyc(4);
    host_rd(2'd1, rd);
    check("R10 stop clears addressed", rd[1], 0);
    check("R4 no irq after stop", irq, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule